// File: doc/BRIEF.md
# Infrared Carrier Range Qualifier

This block sits on the receive side of an infrared remote-control interface. It watches the raw detector output and measures the time between rising edges of the modulated carrier, in system clocks. It then decides whether each carrier cycle is close enough to a programmed centre period. The allowed deviation grows in sixteenth steps with a 3-bit range code. A band select limits the periods that can be accepted at all to either the low band used by consumer remotes (about 27 to 58 kHz) or a high band (about 400 to 500 kHz). Only carrier that passes both tests is turned into a demodulated envelope: pulse while qualified carrier is present, space otherwise.

When demodulation is switched off, the block passes the synchronised raw level straight through. This serves receivers that deliver an already demodulated signal. A receive enable clears every piece of measurement and qualification state, so a receiver that is switched off and on again always starts qualification from the beginning.

Top module: `ir_carrier_qual`

## Requirements
- R1: While `rx_en` is low, and after reset, `envelope`, `rx_active` and `in_range` are 0 on the next clock edge. All measurement state is cleared, so after re-enabling, a pulse again needs a fresh edge followed by two accepted cycles.
- R2: A carrier period is the number of clock cycles between two consecutive rising edges of `ir_in`. The first rising edge after reset or enable produces no measurement. Each decision appears at the outputs on the third rising clock edge after the `ir_in` rising edge that ends the period.
- R3: A measured period P passes the tolerance test when |P − C| ≤ floor(C × n / 16). C is `center_per` and n is `range_code` (0 to 7). With n = 0 only P = C passes.
- R4: `band_hi` = 1 allows only periods from HI_PER_MIN to HI_PER_MAX (defaults 100 to 125 clocks, i.e. 400 to 500 kHz at 50 MHz). `band_hi` = 0 allows only LO_PER_MIN to LO_PER_MAX (defaults 862 to 1852 clocks). A period outside the selected band is rejected even if it passes R3.
- R5: With demodulation on, `rx_active` goes to 1 after the first accepted cycle. If the next measured cycle is rejected before the envelope has reached pulse, `rx_active` returns to 0.
- R6: `envelope` goes to 1 (pulse) after two consecutive accepted cycles. `in_range` shows whether the most recently measured cycle was accepted. A rejected cycle while in pulse clears `in_range` but does not end the pulse.
- R7: When no accepted rising edge has occurred for C + floor(C/2) clocks, `envelope`, `rx_active` and `in_range` all return to 0.
- R8: With `demod_en` = 0, `envelope` and `rx_active` both follow `ir_in` with a latency of three clock edges, and `in_range` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_en | input | 1 | Receive enable; low clears all state |
| ir_in | input | 1 | Raw infrared detector level, asynchronous |
| demod_en | input | 1 | 1 = qualify the carrier, 0 = pass the raw level through |
| band_hi | input | 1 | 1 = high carrier band, 0 = low carrier band |
| center_per | input | PER_W | Centre carrier period in clocks |
| range_code | input | 3 | Tolerance code n, in steps of C/16 |
| envelope | output | 1 | Demodulated level, 1 = pulse |
| in_range | output | 1 | Last measured cycle accepted |
| rx_active | output | 1 | Receiver has locked onto qualified carrier |

## Verification
The hardest state to reach is a rejected carrier cycle that arrives while the envelope is already in pulse, observed before the silence timeout expires. Both the rejection and the hold must be seen in a window only a few dozen clocks wide. The stimulus reaches it by chaining single carrier cycles of chosen lengths, so that one accepted edge is followed by one period that is too long. The outputs are then sampled ten clocks after the offending edge and again after the timeout has passed. The tolerance limit is reached the same way, using periods exactly at and one clock beyond floor(C × n / 16).

// File: rtl/ir_qual_pkg.sv
package ir_qual_pkg;

  typedef enum logic [1:0] {
    QS_IDLE  = 2'd0,
    QS_LOCK  = 2'd1,
    QS_PULSE = 2'd2
  } qual_state_e;

endpackage

// File: rtl/ir_edge_sync.sv
module ir_edge_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ir_in,
  output logic level,
  output logic rise
);

  logic [SYNC:0] sh_q, sh_d;

  always_comb begin
    if (clr) sh_d = '0;
    else     sh_d = {sh_q[SYNC-1:0], ir_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign level = sh_q[SYNC-1];
  assign rise  = sh_q[SYNC-1] & ~sh_q[SYNC];

  // R2
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/ir_period_meter.sv
module ir_period_meter #(
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             rise,
  output logic [PER_W-1:0] period,
  output logic             per_valid
);

  localparam logic [PER_W-1:0] CNT_MAX = {PER_W{1'b1}};

  logic [PER_W-1:0] cnt_q, cnt_d;
  logic             seen_q, seen_d;

  always_comb begin
    cnt_d  = cnt_q;
    seen_d = seen_q;
    if (clr) begin
      cnt_d  = '0;
      seen_d = 1'b0;
    end else if (rise) begin
      cnt_d  = PER_W'(1);
      seen_d = 1'b1;
    end else if (cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
    end
  end

  assign period    = cnt_q;
  assign per_valid = rise & seen_q & ~clr;

endmodule

// File: rtl/ir_cycle_judge.sv
module ir_cycle_judge #(
  parameter int PER_W      = 12,
  parameter int LO_PER_MIN = 862,
  parameter int LO_PER_MAX = 1852,
  parameter int HI_PER_MIN = 100,
  parameter int HI_PER_MAX = 125
) (
  input  logic [PER_W-1:0] period,
  input  logic             per_valid,
  input  logic [PER_W-1:0] center_per,
  input  logic [2:0]       range_code,
  input  logic             band_hi,
  output logic             accept
);

  localparam int PROD_W = PER_W + 3;

  logic [PROD_W-1:0] prod;
  logic [PER_W-1:0]  tol;
  logic [PER_W-1:0]  dev;
  logic [PER_W-1:0]  lim_lo, lim_hi;
  logic              in_band;

  always_comb begin
    prod    = PROD_W'(center_per) * PROD_W'(range_code);
    tol     = PER_W'(prod >> 4);
    dev     = (period >= center_per) ? (period - center_per) : (center_per - period);
    lim_lo  = band_hi ? PER_W'(HI_PER_MIN) : PER_W'(LO_PER_MIN);
    lim_hi  = band_hi ? PER_W'(HI_PER_MAX) : PER_W'(LO_PER_MAX);
    in_band = (period >= lim_lo) && (period <= lim_hi);
    accept  = per_valid && in_band && (dev <= tol);
  end

endmodule

// File: rtl/ir_envelope_fsm.sv
module ir_envelope_fsm
  import ir_qual_pkg::*;
#(
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             demod_en,
  input  logic             level,
  input  logic             per_valid,
  input  logic             accept,
  input  logic [PER_W-1:0] center_per,
  output logic             env_q,
  output logic             act_q,
  output logic             inr_q
);

  localparam int SIL_W = PER_W + 1;
  localparam logic [SIL_W-1:0] SIL_MAX = {SIL_W{1'b1}};

  qual_state_e      st_q, st_d;
  logic [SIL_W-1:0] sil_q, sil_d;
  logic [SIL_W-1:0] tmo;
  logic             env_d, act_d, inr_d;
  logic             acc_rise, rej_rise, expired;

  assign tmo      = SIL_W'(center_per) + SIL_W'(center_per >> 1);
  assign acc_rise = per_valid & accept;
  assign rej_rise = per_valid & ~accept;
  assign expired  = (sil_q >= tmo) & ~acc_rise;

  always_comb begin
    st_d  = st_q;
    sil_d = sil_q;
    inr_d = inr_q;
    if (!rx_en || !demod_en) begin
      st_d  = QS_IDLE;
      sil_d = '0;
      inr_d = 1'b0;
    end else begin
      if (acc_rise)            sil_d = '0;
      else if (sil_q != SIL_MAX) sil_d = sil_q + 1'b1;
      if (per_valid) inr_d = accept;
      unique case (st_q)
        QS_IDLE:  if (acc_rise) st_d = QS_LOCK;
        QS_LOCK:  if (acc_rise) st_d = QS_PULSE;
                  else if (rej_rise || expired) st_d = QS_IDLE;
        QS_PULSE: if (expired) st_d = QS_IDLE;
        default:  st_d = QS_IDLE;
      endcase
      if (expired && st_q != QS_IDLE) inr_d = 1'b0;
    end
  end

  always_comb begin
    if (!rx_en) begin
      env_d = 1'b0;
      act_d = 1'b0;
    end else if (!demod_en) begin
      env_d = level;
      act_d = level;
    end else begin
      env_d = (st_d == QS_PULSE);
      act_d = (st_d != QS_IDLE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= QS_IDLE;
      sil_q <= '0;
      env_q <= 1'b0;
      act_q <= 1'b0;
      inr_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      sil_q <= sil_d;
      env_q <= env_d;
      act_q <= act_d;
      inr_q <= inr_d;
    end
  end

  // R1
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!env_q && !act_q && !inr_q));

  // R6
  pulse_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (demod_en && $past(demod_en) && $rose(env_q)) |-> $past(acc_rise));

  // R5
  pulse_implies_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    env_q |-> act_q);

  // R8
  bypass_no_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !demod_en |=> !inr_q);

  // R7
  silence_ends_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && demod_en && expired) |=> !env_q);

endmodule

// File: rtl/ir_carrier_qual.sv
module ir_carrier_qual #(
  parameter int PER_W      = 12,
  parameter int SYNC       = 2,
  parameter int LO_PER_MIN = 862,
  parameter int LO_PER_MAX = 1852,
  parameter int HI_PER_MIN = 100,
  parameter int HI_PER_MAX = 125
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             ir_in,
  input  logic             demod_en,
  input  logic             band_hi,
  input  logic [PER_W-1:0] center_per,
  input  logic [2:0]       range_code,
  output logic             envelope,
  output logic             in_range,
  output logic             rx_active
);

  logic [1:0]       rst_sh;
  logic             rst_n_s;
  logic             lvl, rise, per_valid, accept;
  logic [PER_W-1:0] period;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_n_s = rst_sh[1];

  ir_edge_sync #(.SYNC(SYNC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr   (~rx_en),
    .ir_in (ir_in),
    .level (lvl),
    .rise  (rise)
  );

  ir_period_meter #(.PER_W(PER_W)) u_meter (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clr       (~rx_en),
    .rise      (rise),
    .period    (period),
    .per_valid (per_valid)
  );

  ir_cycle_judge #(
    .PER_W      (PER_W),
    .LO_PER_MIN (LO_PER_MIN),
    .LO_PER_MAX (LO_PER_MAX),
    .HI_PER_MIN (HI_PER_MIN),
    .HI_PER_MAX (HI_PER_MAX)
  ) u_judge (
    .period     (period),
    .per_valid  (per_valid),
    .center_per (center_per),
    .range_code (range_code),
    .band_hi    (band_hi),
    .accept     (accept)
  );

  ir_envelope_fsm #(.PER_W(PER_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .rx_en      (rx_en),
    .demod_en   (demod_en),
    .level      (lvl),
    .per_valid  (per_valid),
    .accept     (accept),
    .center_per (center_per),
    .env_q      (envelope),
    .act_q      (rx_active),
    .inr_q      (in_range)
  );

endmodule

// File: tb/test_ir_carrier_qual.sv
module test_ir_carrier_qual;

  localparam int PER_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rx_en = 1'b0;
  logic             ir_in = 1'b0;
  logic             demod_en = 1'b1;
  logic             band_hi = 1'b1;
  logic [PER_W-1:0] center_per = 12'd110;
  logic [2:0]       range_code = 3'd1;
  logic             envelope, in_range, rx_active;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    string tag;
    logic  e;
    logic  a;
    logic  r;
  } exp_t;

  exp_t q[$];
  event ev_push;

  always #10 clk = ~clk;

  ir_carrier_qual #(.PER_W(PER_W)) i_ir_carrier_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .ir_in      (ir_in),
    .demod_en   (demod_en),
    .band_hi    (band_hi),
    .center_per (center_per),
    .range_code (range_code),
    .envelope   (envelope),
    .in_range   (in_range),
    .rx_active  (rx_active)
  );

  task automatic expect_now(input string tag, input logic e, input logic a, input logic r);
    exp_t it;
    it.tag = tag; it.e = e; it.a = a; it.r = r;
    q.push_back(it);
    -> ev_push;
    #1;
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic carrier(input int per, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      ir_in = 1'b1;
      wait_neg(per / 2);
      ir_in = 1'b0;
      wait_neg(per - per / 2);
    end
  endtask

  task automatic drain();
    wait_neg(300);
  endtask

  initial begin : monitor
    forever begin
      @(ev_push);
      while (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        n_cmp++;
        if (envelope !== it.e || rx_active !== it.a || in_range !== it.r) begin
          n_bad++;
          $display("FAIL %s: env/act/rng actual %b%b%b expected %b%b%b",
                   it.tag, envelope, rx_active, in_range, it.e, it.a, it.r);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1..all: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : driver
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(4);
    expect_now("R1 reset state", 0, 0, 0);
    rx_en = 1'b1;
    wait_neg(5);

    // R2 R5: first edge gives no measurement, one accepted cycle locks
    carrier(110, 2);
    expect_now("R5 first accepted cycle", 0, 1, 1);
    carrier(110, 1);
    expect_now("R6 second accepted cycle", 1, 1, 1);
    wait_neg(40);
    expect_now("R7 before silence limit", 1, 1, 1);
    wait_neg(30);
    expect_now("R7 after silence limit", 0, 0, 0);
    drain();

    // R3 tolerance edge, n=1 -> tol 6
    carrier(116, 3);
    expect_now("R3 deviation equal to tolerance", 1, 1, 1);
    drain();
    carrier(117, 3);
    expect_now("R3 deviation one beyond tolerance", 0, 0, 0);
    drain();
    range_code = 3'd2;
    carrier(123, 3);
    expect_now("R3 wider code accepts 123", 1, 1, 1);
    drain();
    range_code = 3'd0;
    carrier(111, 3);
    expect_now("R3 code zero rejects 111", 0, 0, 0);
    drain();
    carrier(110, 3);
    expect_now("R3 code zero accepts exact", 1, 1, 1);
    drain();

    // R4 band limits
    range_code = 3'd7;
    carrier(150, 3);
    expect_now("R4 above high band", 0, 0, 0);
    drain();
    band_hi = 1'b0;
    range_code = 3'd1;
    carrier(110, 3);
    expect_now("R4 high period in low band", 0, 0, 0);
    drain();
    center_per = 12'd1000;
    carrier(1060, 3);
    expect_now("R4 low band accepted", 1, 1, 1);
    wait_neg(1600);
    carrier(1070, 3);
    expect_now("R3 low band beyond tolerance", 0, 0, 0);
    wait_neg(1600);
    band_hi = 1'b1;
    center_per = 12'd110;
    drain();

    // R5 R6: reject before pulse drops lock
    carrier(110, 1);
    carrier(140, 1);
    carrier(110, 1);
    expect_now("R5 rejected cycle drops lock", 0, 0, 0);
    carrier(110, 1);
    expect_now("R6 single accepted not enough", 0, 1, 1);
    carrier(110, 1);
    carrier(140, 1);
    ir_in = 1'b1;
    wait_neg(10);
    expect_now("R6 rejected cycle holds pulse", 1, 1, 0);
    wait_neg(30);
    expect_now("R7 pulse ends after silence", 0, 0, 0);
    ir_in = 1'b0;
    drain();

    // R1 disable clears state
    carrier(110, 3);
    expect_now("R1 pulse before disable", 1, 1, 1);
    rx_en = 1'b0;
    wait_neg(1);
    expect_now("R1 disable clears outputs", 0, 0, 0);
    rx_en = 1'b1;
    carrier(110, 2);
    expect_now("R1 requalify after enable", 0, 1, 1);
    drain();

    // R8 bypass latency
    demod_en = 1'b0;
    wait_neg(2);
    ir_in = 1'b1;
    wait_neg(2);
    expect_now("R8 bypass before latency", 0, 0, 0);
    wait_neg(1);
    expect_now("R8 bypass high", 1, 1, 0);
    ir_in = 1'b0;
    wait_neg(3);
    expect_now("R8 bypass low", 0, 0, 0);
    carrier(110, 3);
    expect_now("R8 bypass ignores carrier check", 0, 0, 0);

    wait_neg(2);
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R1: %0d items left unchecked, expected 0", q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule